// File: doc/BRIEF.md
# Multi-Chip-Select Static Memory Bus Sequencer

This block turns single host requests into timed strobe sequences on a parallel bus that serves up to six asynchronous or page/burst static memories. Each chip select owns two timing words: a slow word that sets the per-access wait length, the extra first-access latency for a new page, the write hold and the bus recovery time, and a fast word that sets how long output enable waits after the address strobe and whether the address lingers one extra cycle. A global enable word selects which chip selects may be used. All three kinds of word are loaded through a small write-only configuration port.

The host raises a request with a direction, a chip-select index, an address and write data while the block is idle. The sequencer optionally idles the bus for recovery, pulses address-valid with the chip select, waits out the lead time, holds output enable or write enable for the programmed length, applies write hold, and then pulses done (with read data) in the first idle cycle. A request to a disabled or non-existent chip select is answered with done and an error flag and produces no bus activity. The block remembers the last page and chip select so that the first-access latency is only paid when the page or the chip select changes.

Top module: `smem_bus_seq`

## Requirements
- R1: The enable word occupies bits 9:0 of the configuration data: chip select 0 in bits 1:0, 1 in bits 3:2, 2 in bit 4, 3 in bit 5, 4 in bits 7:6, 5 in bits 9:8; a chip select is usable when its field is non-zero. A request to an unusable chip select, or with index 6 or 7, gets done and error one cycle after acceptance, drives no strobe, and leaves the recovery and page history untouched.
- R2: After reset all chip selects are disabled, every timing word is zero, all strobes (chip selects, address-valid, output enable, write enable) are high, the data bus output is not enabled and the block is ready.
- R3: Ready is high only in the idle state; from acceptance of a usable request until the done cycle ready stays low.
- R4: Exactly one chip-select line, the one named by the request, is low during an access. Address-valid is low in the first chip-select cycle only, with the request address on the address bus.
- R5: Fast word bit 5 set keeps the address on the bus in the cycle after address-valid rises; with it clear the address bus reads zero in that cycle and whenever no address phase is running.
- R6: On a read, output enable goes low max(RD_HOLD, ADV_OE+1) cycles after the first chip-select cycle, with RD_HOLD in fast bits 27:24 and ADV_OE in fast bits 17:16.
- R7: Output enable stays low for read-wait+1 cycles and write enable for write-wait+1 cycles; read-wait is slow bits 3:0 and write-wait slow bits 7:4. On a write, write enable goes low in the cycle right after the address-valid cycle.
- R8: The first access to a page adds the delta field (read: slow bits 15:8, write: slow bits 23:16) to the strobe length. A page is the address above the low PAGE_BITS bits; an access is first when no usable access happened since reset, or the chip select or page differs from the last completed access.
- R9: After write enable rises, the chip select stays low and the write data stays driven for max(WR_HOLD,1) cycles, WR_HOLD being slow bits 27:24; write data is driven in every write-enable and hold cycle.
- R10: When the last completed access was a read and the new request targets another chip select or is a write, the bus idles for RECOVERY+1 cycles before the chip select falls, RECOVERY being slow bits 31:28 of the chip select that was read; otherwise there is no idle gap.
- R11: Done rises in the cycle after the last chip-select cycle; for a read, the read data equals the memory input sampled in the last output-enable cycle.
- R12: Configuration writes select the word by kind (0 enable, 1 slow, 2 fast) and by chip-select index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgKind | input | 2 | Word kind: 0 enable, 1 slow timing, 2 fast timing |
| cfgCs | input | 3 | Chip select addressed by a timing write |
| cfgData | input | 32 | Configuration write data |
| reqValid | input | 1 | Host request valid |
| reqWrite | input | 1 | 1 write, 0 read |
| reqCs | input | 3 | Target chip-select index |
| reqAddr | input | ADDR_W | Access address |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | Block idle, request accepted this cycle when valid |
| rspDone | output | 1 | One-cycle completion pulse |
| rspErr | output | 1 | Request was rejected (with done) |
| rspRdata | output | DATA_W | Read data of the last read |
| memCsN | output | 6 | Active-low chip selects |
| memAdvN | output | 1 | Active-low address-valid strobe |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memAddr | output | ADDR_W | Address bus |
| memDout | output | DATA_W | Write data toward the memory |
| memDoutEn | output | 1 | Data bus driven by the block |
| memDin | input | DATA_W | Read data from the memory |

## Verification
The bench measures every access cycle by cycle at the pins and compares the idle gap, the lead before the strobe, the strobe length, the hold tail and the done cycle with counts computed from the programmed words. It aims at recovery choices (read then write on one chip select, read then another chip select, write then read, and a rejected request in between), where a wrong rule would add or drop a whole idle gap or take the gap length from the wrong chip select. Back-to-back accesses inside one page and across pages catch a design that always or never pays the delta, and a zero write-hold field catches a hold tail of zero. Output enable is released by the bench's memory model outside the strobe window, so sampling read data one cycle late or early returns a marker value instead of the expected data.

// File: rtl/smem_pkg.sv
package smem_pkg;

  localparam int NUM_CS   = 6;
  localparam int CS_IDX_W = 3;
  localparam int EN_W     = 10;
  localparam int CNT_W    = 9;   // 15 wait + 255 delta fits

  // Slow timing word; member order matches the bit layout of the word.
  typedef struct packed {
    logic [3:0] recov;
    logic [3:0] wrHold;
    logic [7:0] wrDelta;
    logic [7:0] rdDelta;
    logic [3:0] wrWait;
    logic [3:0] rdWait;
  } slowCfg_t;

  typedef struct packed {
    logic [3:0] rdHold;
    logic [1:0] advOe;
    logic       addrHold;
  } fastCfg_t;

  typedef enum logic [1:0] {
    CFG_ENABLE = 2'd0,
    CFG_SLOW   = 2'd1,
    CFG_FAST   = 2'd2
  } cfgKind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECOV,
    ST_ADDR,
    ST_LEAD,
    ST_ACTIVE,
    ST_HOLD
  } seqState_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic latchReq;
    logic commit;
    logic capture;
    logic csOn;
    logic advOn;
    logic oeOn;
    logic weOn;
    logic doutOn;
    logic addrOn;
  } busCtl_t;

  function automatic logic csEnabled(input logic [EN_W-1:0] en,
                                     input logic [CS_IDX_W-1:0] idx);
    case (idx)
      3'd0:    return |en[1:0];
      3'd1:    return |en[3:2];
      3'd2:    return en[4];
      3'd3:    return en[5];
      3'd4:    return |en[7:6];
      3'd5:    return |en[9:8];
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/smem_datapath.sv
module smem_datapath
  import smem_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int PAGE_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [1:0]          cfgKind,
  input  logic [CS_IDX_W-1:0] cfgCs,
  input  logic [31:0]         cfgData,
  input  logic [CS_IDX_W-1:0] reqCs,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  busCtl_t             ctl,
  input  logic [DATA_W-1:0]   memDin,
  output logic                reqLegal,
  output logic                needRecov,
  output logic [3:0]          histRecov,
  output logic                curWrite,
  output logic                curFirst,
  output slowCfg_t            selSlow,
  output fastCfg_t            selFast,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_CS-1:0]   memCsN,
  output logic                memAdvN,
  output logic                memOeN,
  output logic                memWeN,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memDout,
  output logic                memDoutEn
);

  localparam int PAGE_W = ADDR_W - PAGE_BITS;

  logic [EN_W-1:0]     enReg;
  slowCfg_t            slowRegs [NUM_CS];
  fastCfg_t            fastRegs [NUM_CS];

  logic [CS_IDX_W-1:0] curCs, selCs, histCs;
  logic [ADDR_W-1:0]   addrQ;
  logic [DATA_W-1:0]   wdataQ;
  logic                histValid, histRead;
  logic [PAGE_W-1:0]   histPage;
  logic                reqFirst;

  logic unusedCfgBits;
  assign unusedCfgBits = ^{cfgData[31:28], cfgData[23:18], cfgData[15:6], cfgData[4:0]};

  // Configuration words (R12)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg <= '0;
      for (int i = 0; i < NUM_CS; i++) begin
        slowRegs[i] <= '0;
        fastRegs[i] <= '0;
      end
    end else if (cfgWe) begin
      if (cfgKind == CFG_ENABLE) enReg <= cfgData[EN_W-1:0];
      for (int i = 0; i < NUM_CS; i++) begin
        if (cfgCs == CS_IDX_W'(i)) begin
          if (cfgKind == CFG_SLOW) slowRegs[i] <= slowCfg_t'(cfgData);
          if (cfgKind == CFG_FAST)
            fastRegs[i] <= '{rdHold: cfgData[27:24], advOe: cfgData[17:16],
                             addrHold: cfgData[5]};
        end
      end
    end
  end

  // While a request is being accepted its own chip select is looked up.
  assign selCs = ctl.latchReq ? reqCs : curCs;

  always_comb begin
    selSlow   = '0;
    selFast   = '0;
    histRecov = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (selCs == CS_IDX_W'(i)) begin
        selSlow = slowRegs[i];
        selFast = fastRegs[i];
      end
      if (histCs == CS_IDX_W'(i)) histRecov = slowRegs[i].recov;
    end
  end

  assign reqLegal  = csEnabled(enReg, reqCs);
  assign needRecov = histValid && histRead && ((reqCs != histCs) || reqWrite);
  assign reqFirst  = !histValid || (reqCs != histCs) ||
                     (reqAddr[ADDR_W-1:PAGE_BITS] != histPage);

  // Request latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCs    <= '0;
      curWrite <= 1'b0;
      curFirst <= 1'b0;
      addrQ    <= '0;
      wdataQ   <= '0;
    end else if (ctl.latchReq) begin
      curCs    <= reqCs;
      curWrite <= reqWrite;
      curFirst <= reqFirst;
      addrQ    <= reqAddr;
      wdataQ   <= reqWdata;
    end
  end

  // Recovery and page history, updated only by completed accesses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histValid <= 1'b0;
      histRead  <= 1'b0;
      histCs    <= '0;
      histPage  <= '0;
    end else if (ctl.commit) begin
      histValid <= 1'b1;
      histRead  <= !curWrite;
      histCs    <= curCs;
      histPage  <= addrQ[ADDR_W-1:PAGE_BITS];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (ctl.capture) rdData <= memDin;
  end

  // Pin drive
  for (genvar g = 0; g < NUM_CS; g++) begin : gCsPin
    assign memCsN[g] = !(ctl.csOn && (curCs == CS_IDX_W'(g)));
  end

  assign memAdvN   = !ctl.advOn;
  assign memOeN    = !ctl.oeOn;
  assign memWeN    = !ctl.weOn;
  assign memDoutEn = ctl.doutOn;
  assign memDout   = ctl.doutOn ? wdataQ : '0;
  assign memAddr   = ctl.addrOn ? addrQ : '0;

  p_cs_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCsN));

  p_adv_inside_cs_r4: assert property (@(posedge clk) disable iff (!rstN)
    !memAdvN |-> (memCsN != '1));

  p_oe_we_apart_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

  p_we_release_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (memDoutEn && (memCsN != '1)));

endmodule

// File: rtl/smem_control.sv
module smem_control
  import smem_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqLegal,
  input  logic     needRecov,
  input  logic [3:0] histRecov,
  input  logic     curWrite,
  input  logic     curFirst,
  input  slowCfg_t selSlow,
  input  fastCfg_t selFast,
  output logic     reqReady,
  output logic     rspDone,
  output logic     rspErr,
  output busCtl_t  ctl
);

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             doneNext, errNext, advPrevQ;
  logic [4:0]       advPlus, holdExt, leadCycles;
  logic [CNT_W-1:0] activeLoad, holdLoad;
  logic             cntZero;

  assign cntZero = (cnt == '0);

  // Cycles from chip-select fall to output-enable fall (R6)
  always_comb begin
    advPlus    = 5'({3'b000, selFast.advOe}) + 5'd1;
    holdExt    = {1'b0, selFast.rdHold};
    leadCycles = (holdExt > advPlus) ? holdExt : advPlus;
  end

  // Strobe length minus one (R7, R8) and hold length minus one (R9)
  always_comb begin
    if (curWrite)
      activeLoad = CNT_W'(selSlow.wrWait) +
                   (curFirst ? CNT_W'(selSlow.wrDelta) : CNT_W'(0));
    else
      activeLoad = CNT_W'(selSlow.rdWait) +
                   (curFirst ? CNT_W'(selSlow.rdDelta) : CNT_W'(0));
    holdLoad = (selSlow.wrHold == 4'd0) ? CNT_W'(0) : CNT_W'(selSlow.wrHold) - CNT_W'(1);
  end

  always_comb begin
    stateNext    = state;
    cntNext      = cnt;
    doneNext     = 1'b0;
    errNext      = 1'b0;
    ctl          = '0;
    ctl.latchReq = (state == ST_IDLE) && reqValid;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (!reqLegal) begin
            doneNext = 1'b1;
            errNext  = 1'b1;
          end else if (needRecov) begin
            stateNext = ST_RECOV;
            cntNext   = CNT_W'(histRecov);
          end else begin
            stateNext = ST_ADDR;
          end
        end
      end
      ST_RECOV: begin
        if (cntZero) stateNext = ST_ADDR;
        else         cntNext   = cnt - CNT_W'(1);
      end
      ST_ADDR: begin
        if (curWrite || (leadCycles == 5'd1)) begin
          stateNext = ST_ACTIVE;
          cntNext   = activeLoad;
        end else begin
          stateNext = ST_LEAD;
          cntNext   = CNT_W'(leadCycles) - CNT_W'(2);
        end
      end
      ST_LEAD: begin
        if (cntZero) begin
          stateNext = ST_ACTIVE;
          cntNext   = activeLoad;
        end else begin
          cntNext = cnt - CNT_W'(1);
        end
      end
      ST_ACTIVE: begin
        if (!cntZero) begin
          cntNext = cnt - CNT_W'(1);
        end else if (curWrite) begin
          stateNext = ST_HOLD;
          cntNext   = holdLoad;
        end else begin
          stateNext   = ST_IDLE;
          ctl.capture = 1'b1;
          ctl.commit  = 1'b1;
          doneNext    = 1'b1;
        end
      end
      ST_HOLD: begin
        if (cntZero) begin
          stateNext  = ST_IDLE;
          ctl.commit = 1'b1;
          doneNext   = 1'b1;
        end else begin
          cntNext = cnt - CNT_W'(1);
        end
      end
      default: stateNext = ST_IDLE;
    endcase

    ctl.csOn   = (state == ST_ADDR) || (state == ST_LEAD) ||
                 (state == ST_ACTIVE) || (state == ST_HOLD);
    ctl.advOn  = (state == ST_ADDR);
    ctl.oeOn   = (state == ST_ACTIVE) && !curWrite;
    ctl.weOn   = (state == ST_ACTIVE) && curWrite;
    ctl.doutOn = ((state == ST_ACTIVE) || (state == ST_HOLD)) && curWrite;
    ctl.addrOn = (state == ST_ADDR) || (advPrevQ && selFast.addrHold);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rspDone  <= 1'b0;
      rspErr   <= 1'b0;
      advPrevQ <= 1'b0;
    end else begin
      state    <= stateNext;
      cnt      <= cntNext;
      rspDone  <= doneNext;
      rspErr   <= errNext;
      advPrevQ <= (state == ST_ADDR);
    end
  end

  assign reqReady = (state == ST_IDLE);

  p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqLegal) |=> !reqReady);

  p_err_with_done_r1: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspDone);

  p_done_bus_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> !ctl.csOn);

endmodule

// File: rtl/smem_bus_seq.sv
module smem_bus_seq
  import smem_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int PAGE_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [1:0]          cfgKind,
  input  logic [2:0]          cfgCs,
  input  logic [31:0]         cfgData,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [2:0]          reqCs,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                reqReady,
  output logic                rspDone,
  output logic                rspErr,
  output logic [DATA_W-1:0]   rspRdata,
  output logic [5:0]          memCsN,
  output logic                memAdvN,
  output logic                memOeN,
  output logic                memWeN,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memDout,
  output logic                memDoutEn,
  input  logic [DATA_W-1:0]   memDin
);

  busCtl_t    ctl;
  slowCfg_t   selSlow;
  fastCfg_t   selFast;
  logic       reqLegal, needRecov, curWrite, curFirst;
  logic [3:0] histRecov;

  smem_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)
  ) uDatapath (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgKind(cfgKind), .cfgCs(cfgCs), .cfgData(cfgData),
    .reqCs(reqCs), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .ctl(ctl), .memDin(memDin),
    .reqLegal(reqLegal), .needRecov(needRecov), .histRecov(histRecov),
    .curWrite(curWrite), .curFirst(curFirst),
    .selSlow(selSlow), .selFast(selFast), .rdData(rspRdata),
    .memCsN(memCsN), .memAdvN(memAdvN), .memOeN(memOeN), .memWeN(memWeN),
    .memAddr(memAddr), .memDout(memDout), .memDoutEn(memDoutEn)
  );

  smem_control uControl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqLegal(reqLegal), .needRecov(needRecov),
    .histRecov(histRecov), .curWrite(curWrite), .curFirst(curFirst),
    .selSlow(selSlow), .selFast(selFast),
    .reqReady(reqReady), .rspDone(rspDone), .rspErr(rspErr), .ctl(ctl)
  );

endmodule

// File: tb/smem_bus_seq_test.sv
module smem_bus_seq_test;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int PB = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [1:0]    cfgKind = '0;
  logic [2:0]    cfgCs = '0;
  logic [31:0]   cfgData = '0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [2:0]    reqCs = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          reqReady, rspDone, rspErr;
  logic [DW-1:0] rspRdata;
  logic [5:0]    memCsN;
  logic          memAdvN, memOeN, memWeN, memDoutEn;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memDout, memDin;
  logic [DW-1:0] rdVal = '0;

  int nChecks = 0;
  int nFails  = 0;

  // Model state
  logic [31:0] slowW [6];
  logic [31:0] fastW [6];
  logic [9:0]  enW = '0;
  bit          mValid = 0;
  bit          mRead = 0;
  int          mCs = 0;
  int          mPage = 0;

  always #10 clk = ~clk;

  // Memory answers only while output enable is low.
  assign memDin = memOeN ? 16'hBAD0 : rdVal;

  smem_bus_seq #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(PB)) uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgKind(cfgKind), .cfgCs(cfgCs),
    .cfgData(cfgData), .reqValid(reqValid), .reqWrite(reqWrite), .reqCs(reqCs),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady), .rspDone(rspDone),
    .rspErr(rspErr), .rspRdata(rspRdata), .memCsN(memCsN), .memAdvN(memAdvN),
    .memOeN(memOeN), .memWeN(memWeN), .memAddr(memAddr), .memDout(memDout),
    .memDoutEn(memDoutEn), .memDin(memDin)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit expEnabled(input logic [9:0] e, input int cs);
    case (cs)
      0: return |e[1:0];
      1: return |e[3:2];
      2: return e[4];
      3: return e[5];
      4: return |e[7:6];
      5: return |e[9:8];
      default: return 0;
    endcase
  endfunction

  function automatic int expLeadRead(input logic [31:0] f);
    int h = int'(f[27:24]);
    int a = int'(f[17:16]) + 1;
    return (h > a) ? h : a;
  endfunction

  task automatic cfgWrite(input int kind, input int cs, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgKind = 2'(kind); cfgCs = 3'(cs); cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
    if (kind == 0) enW = d[9:0];
    else if (cs < 6) begin
      if (kind == 1) slowW[cs] = d;
      if (kind == 2) fastW[cs] = d;
    end
  endtask

  task automatic doTxn(input bit w, input int cs, input logic [AW-1:0] addr,
                       input logic [DW-1:0] wd);
    bit legal = expEnabled(enW, cs);
    bit first, seenCs;
    int expIdle, expLead, expAct, expTail;
    int idleB, lead, act, tail, csCycle, doneAt, errAt;
    int advBad, addrBad, csBad, doutBad, readyBad;
    logic [31:0] s, f;
    s = (cs < 6) ? slowW[cs] : 32'd0;
    f = (cs < 6) ? fastW[cs] : 32'd0;
    first   = !mValid || (cs != mCs) || (int'(addr >> PB) != mPage);
    expIdle = (mValid && mRead && (cs != mCs || w)) ? int'(slowW[mCs][31:28]) + 1 : 0;
    expLead = w ? 1 : expLeadRead(f);
    expAct  = w ? int'(s[7:4]) + 1 + (first ? int'(s[23:16]) : 0)
                : int'(s[3:0]) + 1 + (first ? int'(s[15:8]) : 0);
    expTail = w ? ((s[27:24] == 0) ? 1 : int'(s[27:24])) : 0;
    rdVal   = 16'($urandom);
    if (rdVal == 16'hBAD0) rdVal = 16'h1234;

    // present request; block is idle here
    reqValid = 1'b1; reqWrite = w; reqCs = 3'(cs); reqAddr = addr; reqWdata = wd;
    check(reqReady == 1'b1, "R3", "ready before request", int'(reqReady), 1);
    @(posedge clk);
    seenCs = 0; idleB = 0; lead = 0; act = 0; tail = 0; csCycle = 0;
    doneAt = 0; errAt = 0; advBad = 0; addrBad = 0; csBad = 0; doutBad = 0; readyBad = 0;
    for (int k = 1; k <= 700 && doneAt == 0; k++) begin
      @(negedge clk);
      if (k == 1) reqValid = 1'b0;
      if (rspDone) begin
        doneAt = k;
        errAt  = int'(rspErr);
      end else begin
        if (reqReady) readyBad++;
        if (memCsN == 6'h3f) begin
          if (!seenCs) idleB++;
          if (!memAdvN || !memOeN || !memWeN) csBad++;
        end else begin
          if (cs > 5 || memCsN != ~(6'b1 << cs)) csBad++;
          if (csCycle == 0) begin
            if (memAdvN !== 1'b0 || memAddr !== addr) advBad++;
          end else begin
            if (memAdvN !== 1'b1) advBad++;
            if (csCycle == 1 && memAddr !== (f[5] ? addr : '0)) addrBad++;
          end
          csCycle++;
          seenCs = 1;
          if ((w && !memOeN) || (!w && !memWeN)) csBad++;
          if (!memOeN || !memWeN) act++;
          else if (act == 0) lead++;
          else tail++;
          if (w && act > 0 && (!memDoutEn || memDout !== wd)) doutBad++;
          if (!w && memDoutEn) doutBad++;
        end
      end
    end
    if (!legal) begin
      check(doneAt == 1, "R1", "reject done cycle", doneAt, 1);
      check(errAt == 1, "R1", "reject error flag", errAt, 1);
      check(!seenCs, "R1", "reject bus activity", int'(seenCs), 0);
    end else begin
      check(doneAt != 0, "R11", "done seen", doneAt, 1);
      check(errAt == 0, "R1", "error on legal access", errAt, 0);
      check(idleB == expIdle, "R10", "recovery idle cycles", idleB, expIdle);
      check(lead == expLead, w ? "R7" : "R6", "lead cycles", lead, expLead);
      check(act == expAct, "R7/R8", "strobe cycles", act, expAct);
      check(tail == expTail, "R9", "hold cycles", tail, expTail);
      check(doneAt == idleB + lead + act + tail + 1, "R11", "done position",
            doneAt, idleB + lead + act + tail + 1);
      check(advBad == 0 && csBad == 0, "R4", "strobe pattern faults", advBad + csBad, 0);
      check(addrBad == 0, "R5", "address hold faults", addrBad, 0);
      check(doutBad == 0, "R9", "write data drive faults", doutBad, 0);
      check(readyBad == 0, "R3", "ready while busy", readyBad, 0);
      if (!w) check(rspRdata == rdVal, "R11", "read data", int'(rspRdata), int'(rdVal));
      mValid = 1; mRead = !w; mCs = cs; mPage = int'(addr >> PB);
    end
  endtask

  function automatic logic [AW-1:0] pickAddr();
    return AW'((($urandom % 4) << PB) | ($urandom % 16) | 32'h3000);
  endfunction

  initial begin
    int seedInit;
    seedInit = $urandom(20240611);
    for (int i = 0; i < 6; i++) begin slowW[i] = '0; fastW[i] = '0; end
    repeat (3) @(negedge clk);
    // R2: reset state
    check(reqReady == 1'b1, "R2", "ready in reset", int'(reqReady), 1);
    check(memCsN == 6'h3f && memAdvN && memOeN && memWeN, "R2", "strobes idle",
          int'(memCsN), 63);
    check(!memDoutEn && !rspDone, "R2", "dout/done low", int'(memDoutEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1/R2: everything disabled after reset
    doTxn(0, 0, 20'h00010, 16'h0);
    // R12/R1: enable word with mixed field values
    cfgWrite(0, 0, 32'b00_11_0_1_01_10);
    cfgWrite(1, 0, {4'd3, 4'd0, 8'd5, 8'd7, 4'd2, 4'd4});
    cfgWrite(2, 0, 32'h0203_0020);            // rdHold 2, advOe 3, addrHold
    cfgWrite(1, 1, {4'd0, 4'd3, 8'd0, 8'd20, 4'd0, 4'd0});
    cfgWrite(2, 1, 32'h0600_0000);            // rdHold 6, advOe 0
    cfgWrite(1, 2, {4'd9, 4'd1, 8'd2, 8'd3, 4'd15, 4'd15});
    cfgWrite(2, 2, 32'h0001_0000);
    cfgWrite(1, 4, {4'd1, 4'd0, 8'd1, 8'd1, 4'd1, 4'd1});
    cfgWrite(2, 4, 32'h0F02_0020);
    cfgWrite(1, 6, 32'hFFFF_FFFF);            // index 6: no word exists
    @(negedge clk);
    doTxn(0, 0, 20'h00120, 16'h0);  // first read: delta
    doTxn(0, 0, 20'h00125, 16'h0);  // same page: no delta, no recovery (R8)
    doTxn(1, 0, 20'h0012A, 16'hA5A5); // read->write same cs: recovery (R10)
    doTxn(0, 1, 20'h00200, 16'h0);  // write->read other cs: no recovery
    doTxn(0, 0, 20'h00120, 16'h0);  // read cs1 -> cs0: recovery of cs1
    doTxn(0, 3, 20'h00120, 16'h0);  // cs3 field zero: reject (R1)
    doTxn(0, 7, 20'h00120, 16'h0);  // index 7: reject (R1)
    doTxn(0, 5, 20'h00120, 16'h0);  // cs5 field zero: reject
    doTxn(0, 0, 20'h00121, 16'h0);  // history unchanged by rejects
    doTxn(1, 4, 20'h00400, 16'h5A5A); // hold field zero -> one hold cycle (R9)
    doTxn(0, 2, 20'h00500, 16'h0);  // long waits
    doTxn(0, 1, 20'h00210, 16'h0);  // new page on cs1, rdHold lead
    for (int n = 0; n < 220; n++) begin
      if (n % 40 == 0) begin
        for (int c = 0; c < 6; c++) begin
          cfgWrite(1, c, $urandom);
          cfgWrite(2, c, $urandom);
        end
        cfgWrite(0, 0, {22'd0, 10'($urandom)});
      end
      doTxn($urandom % 2, ($urandom % 8 == 7) ? int'($urandom % 8) : int'($urandom % 6),
            pickAddr(), 16'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule